// File: doc/BRIEF.md
# Compensation Code Scale and Apply Unit

This block sits between an impedance and current calibration engine and four analog consumers: receiver gain, receiver termination, transmitter and current reference. Every channel takes its raw calibration code and multiplies it by its own unsigned 8-bit scale, which has one integer bit and seven fraction bits. It then adds its own signed 8-bit offset and clamps the result to an 8-bit final code. Software can write a final code directly, and that value then replaces the computed one.

The analog-facing outputs are not driven by the final code directly. Each channel keeps an applied copy that changes only when that channel's one-cycle ready strobe arrives. Each target receives only the upper bits of its applied code.

A 32-bit register port gives access to three register words: final code (selector 0), scale (selector 1) and offset (selector 2). Each channel owns one byte lane. From the top byte down the lanes are receiver gain, receiver termination, transmitter and current reference. The opcode is 0 for a read and 1 for a write. A small state machine handles read responses. It has two states, `BUS_IDLE` and `BUS_RDRESP`. An accepted read moves it to `BUS_RDRESP` for exactly one cycle. From `BUS_RDRESP` it returns to `BUS_IDLE` unless another read is accepted, in which case it stays. Anything other than an accepted read leads to `BUS_IDLE`.

Top module: `comp_code_unit`

## Requirements
- R1: After reset, every final-code byte and every scale byte reads 0x80 and every offset byte reads 0x00. The override is active on all channels. The outputs show the upper bits of 0x80: gain 0x20, termination 0x40, transmitter 0x40, reference 0x20.
- R2: While a channel is not overridden, its final code is floor(raw × scale / 128) + offset, with the offset taken as two's complement. It reflects the raw code present one clock earlier. Scale examples: 0x80 = 1.0, 0xC0 = 1.5, 0x40 = 0.5, 0x00 = 0.
- R3: A sum above 255 gives a final code of 255.
- R4: A sum below 0 gives a final code of 0.
- R5: Writing a byte to selector 0 stores that byte as the channel's final code and sets the override. While the override is set, changes of the raw code have no effect on the final code.
- R6: Writing a byte to the scale (selector 1) or offset (selector 2) of a channel clears that channel's override. From then on the final code is computed again.
- R7: Byte enable bit i (bit 3 = gain, 2 = termination, 1 = transmitter, 0 = reference) gates the write of lane i. Lanes whose enable is low keep their values.
- R8: A channel's output holds its value in every cycle without that channel's ready strobe.
- R9: On a ready strobe the channel applies its final code. Termination and transmitter output bits [7:1], reference outputs bits [7:2], and gain outputs the upper GAIN_KEEP bits (6 by default).
- R10: A ready strobe in the same cycle as a register write applies the value that the write produces.
- R11: A read gives rvalid high in the next cycle only, with the selected word on rdata. Selector 3 reads as zero, and writes to selector 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_code_i | input | 32 | Raw calibration codes, one byte per lane |
| ready_i | input | 4 | Per-lane apply strobes |
| bus_valid_i | input | 1 | Register request valid |
| bus_op_i | input | 1 | 0 read, 1 write |
| bus_addr_i | input | 2 | Register selector |
| bus_be_i | input | 4 | Per-lane write enables |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 32 | Read data |
| gain_code_o | output | GAIN_KEEP | Receiver gain target code |
| term_code_o | output | 7 | Receiver termination target code |
| tx_code_o | output | 7 | Transmitter target code |
| iref_code_o | output | 6 | Current reference target code |

## Verification
The bench builds the unit with its default GAIN_KEEP of 6. At that width the gain lane drops the same two low bits as the reference lane, while termination and transmitter drop only one. A single strobe pattern can therefore show both truncation widths side by side. The bench models the arithmetic with wide integers, so scale values of 0, 0.5, 1.5 and nearly 2, combined with offsets of both signs, reach both clamp limits.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
    localparam int LANES = 4;
    localparam int CW    = 8;
    localparam logic [CW-1:0] RESET_CODE = 8'h80;

    typedef enum logic {OP_READ = 1'b0, OP_WRITE = 1'b1} bus_op_e;

    typedef enum logic [1:0] {
        SEL_FINAL  = 2'd0,
        SEL_SCALE  = 2'd1,
        SEL_OFFSET = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef enum logic {BUS_IDLE = 1'b0, BUS_RDRESP = 1'b1} bus_state_e;
endpackage

// File: rtl/ccu_arith.sv
module ccu_arith #(
    parameter int CODE_W = 8,
    parameter int FRAC   = 7
) (
    input  logic [CODE_W-1:0] raw_i,
    input  logic [CODE_W-1:0] scale_i,
    input  logic [CODE_W-1:0] offset_i,
    output logic [CODE_W-1:0] code_o
);
    localparam int PW = 2 * CODE_W;
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] MAXV = SW'((1 << CODE_W) - 1);

    logic [PW-1:0]        prod;
    logic [PW-1:0]        prod_sh;
    logic signed [SW-1:0] sum_w;

    always_comb begin
        prod    = PW'(raw_i) * PW'(scale_i);
        prod_sh = prod >> FRAC;
        sum_w   = $signed({2'b00, prod_sh})
                + $signed({{(SW-CODE_W){offset_i[CODE_W-1]}}, offset_i});
        if (sum_w < 0)
            code_o = '0;
        else if (sum_w > MAXV)
            code_o = '1;
        else
            code_o = sum_w[CODE_W-1:0];
    end
endmodule

// File: rtl/ccu_chan.sv
module ccu_chan #(
    parameter int CODE_W = 8,
    parameter int FRAC   = 7,
    parameter logic [CODE_W-1:0] INIT = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] raw_i,
    input  logic              ready_i,
    input  logic              wr_final_i,
    input  logic              wr_scale_i,
    input  logic              wr_off_i,
    input  logic [CODE_W-1:0] wdata_i,
    output logic [CODE_W-1:0] scale_o,
    output logic [CODE_W-1:0] offset_o,
    output logic [CODE_W-1:0] final_o,
    output logic [CODE_W-1:0] active_o
);
    localparam logic [CODE_W-1:0] UNITY = CODE_W'(1 << FRAC);

    logic [CODE_W-1:0] scale_q, off_q, ovv_q, final_q, active_q;
    logic              ovf_q;
    logic [CODE_W-1:0] scale_d, off_d, ovv_d, comp_d, final_d;
    logic              ovf_d;

    // next register contents, so a strobe in a write cycle sees the write
    always_comb begin
        scale_d = scale_q;
        off_d   = off_q;
        ovv_d   = ovv_q;
        ovf_d   = ovf_q;
        if (wr_final_i) begin
            ovv_d = wdata_i;
            ovf_d = 1'b1;
        end
        if (wr_scale_i) begin
            scale_d = wdata_i;
            ovf_d   = 1'b0;
        end
        if (wr_off_i) begin
            off_d = wdata_i;
            ovf_d = 1'b0;
        end
    end

    ccu_arith #(.CODE_W(CODE_W), .FRAC(FRAC)) u_arith (
        .raw_i    (raw_i),
        .scale_i  (scale_d),
        .offset_i (off_d),
        .code_o   (comp_d)
    );

    assign final_d = ovf_d ? ovv_d : comp_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scale_q  <= INIT;
            off_q    <= '0;
            ovv_q    <= INIT;
            ovf_q    <= 1'b1;
            final_q  <= INIT;
            active_q <= INIT;
        end else begin
            scale_q <= scale_d;
            off_q   <= off_d;
            ovv_q   <= ovv_d;
            ovf_q   <= ovf_d;
            final_q <= final_d;
            if (ready_i)
                active_q <= final_d;
        end
    end

    assign scale_o  = scale_q;
    assign offset_o = off_q;
    assign final_o  = final_q;
    assign active_o = active_q;

    // R2
    unity_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_d && scale_d == UNITY && off_d == '0) |=> final_q == $past(raw_i));
    // R5
    ovr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_final_i |=> (ovf_q && final_q == $past(wdata_i)));
    // R6
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_scale_i || wr_off_i) |=> !ovf_q);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> $stable(active_q));
    // R10
    apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> active_q == final_q);
endmodule

// File: rtl/ccu_regif.sv
module ccu_regif
    import ccu_pkg::*;
#(
    parameter int NL   = 4,
    parameter int CODE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_i,
    input  logic                 op_i,
    input  logic [1:0]           addr_i,
    input  logic [NL-1:0]        be_i,
    input  logic [NL*CODE_W-1:0] final_i,
    input  logic [NL*CODE_W-1:0] scale_i,
    input  logic [NL*CODE_W-1:0] offset_i,
    output logic [NL-1:0]        wr_final_o,
    output logic [NL-1:0]        wr_scale_o,
    output logic [NL-1:0]        wr_off_o,
    output logic                 rvalid_o,
    output logic [NL*CODE_W-1:0] rdata_o
);
    bus_state_e state_q, state_d;
    bus_op_e    op;
    reg_sel_e   sel;
    logic       rd_acc, wr_acc;
    logic [NL*CODE_W-1:0] rdata_q, rsel;

    assign op     = bus_op_e'(op_i);
    assign sel    = reg_sel_e'(addr_i);
    assign rd_acc = valid_i && (op == OP_READ);
    assign wr_acc = valid_i && (op == OP_WRITE);

    // next state
    always_comb begin
        state_d = BUS_IDLE;
        unique case (state_q)
            BUS_IDLE:   state_d = rd_acc ? BUS_RDRESP : BUS_IDLE;
            BUS_RDRESP: state_d = rd_acc ? BUS_RDRESP : BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // read data select and capture
    always_comb begin
        rsel = '0;
        unique case (sel)
            SEL_FINAL:  rsel = final_i;
            SEL_SCALE:  rsel = scale_i;
            SEL_OFFSET: rsel = offset_i;
            SEL_SPARE:  rsel = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_acc) rdata_q <= rsel;
    end

    // outputs
    always_comb begin
        rvalid_o   = (state_q == BUS_RDRESP);
        rdata_o    = rdata_q;
        wr_final_o = (wr_acc && sel == SEL_FINAL)  ? be_i : '0;
        wr_scale_o = (wr_acc && sel == SEL_SCALE)  ? be_i : '0;
        wr_off_o   = (wr_acc && sel == SEL_OFFSET) ? be_i : '0;
    end

    // R11
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rvalid_o);
    // R11
    no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rvalid_o);
endmodule

// File: rtl/comp_code_unit.sv
module comp_code_unit
    import ccu_pkg::*;
#(
    parameter int GAIN_KEEP = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LANES*CW-1:0]  raw_code_i,
    input  logic [LANES-1:0]     ready_i,
    input  logic                 bus_valid_i,
    input  logic                 bus_op_i,
    input  logic [1:0]           bus_addr_i,
    input  logic [LANES-1:0]     bus_be_i,
    input  logic [LANES*CW-1:0]  bus_wdata_i,
    output logic                 bus_rvalid_o,
    output logic [LANES*CW-1:0]  bus_rdata_o,
    output logic [GAIN_KEEP-1:0] gain_code_o,
    output logic [CW-2:0]        term_code_o,
    output logic [CW-2:0]        tx_code_o,
    output logic [CW-3:0]        iref_code_o
);
    localparam int L_GAIN = 3;
    localparam int L_TERM = 2;
    localparam int L_TX   = 1;
    localparam int L_IREF = 0;
    localparam int DW     = LANES * CW;

    logic [LANES-1:0] wr_final, wr_scale, wr_off;
    logic [DW-1:0]    final_w, scale_w, off_w, active_w;

    ccu_regif #(.NL(LANES), .CODE_W(CW)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (bus_valid_i),
        .op_i       (bus_op_i),
        .addr_i     (bus_addr_i),
        .be_i       (bus_be_i),
        .final_i    (final_w),
        .scale_i    (scale_w),
        .offset_i   (off_w),
        .wr_final_o (wr_final),
        .wr_scale_o (wr_scale),
        .wr_off_o   (wr_off),
        .rvalid_o   (bus_rvalid_o),
        .rdata_o    (bus_rdata_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        ccu_chan #(.CODE_W(CW), .FRAC(CW-1), .INIT(RESET_CODE)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .raw_i      (raw_code_i[g*CW +: CW]),
            .ready_i    (ready_i[g]),
            .wr_final_i (wr_final[g]),
            .wr_scale_i (wr_scale[g]),
            .wr_off_i   (wr_off[g]),
            .wdata_i    (bus_wdata_i[g*CW +: CW]),
            .scale_o    (scale_w[g*CW +: CW]),
            .offset_o   (off_w[g*CW +: CW]),
            .final_o    (final_w[g*CW +: CW]),
            .active_o   (active_w[g*CW +: CW])
        );
    end

    assign gain_code_o = active_w[L_GAIN*CW+CW-1 -: GAIN_KEEP];
    assign term_code_o = active_w[L_TERM*CW+CW-1 -: CW-1];
    assign tx_code_o   = active_w[L_TX*CW+CW-1   -: CW-1];
    assign iref_code_o = active_w[L_IREF*CW+CW-1 -: CW-2];
endmodule

// File: tb/tb_comp_code_unit.sv
`timescale 1ns/1ps
module tb_comp_code_unit;
    localparam int GK = 6;

    logic        clk = 0, rst_n = 0;
    logic [31:0] raw = 0;
    logic [3:0]  rdy = 0;
    logic        bv = 0, bop = 0;
    logic [1:0]  badr = 0;
    logic [3:0]  bbe = 0;
    logic [31:0] bwd = 0;
    logic        rvalid;
    logic [31:0] rdata;
    logic [GK-1:0] gain_o;
    logic [6:0]  term_o, tx_o;
    logic [5:0]  iref_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [7:0] m_scale[4], m_off[4], m_ovv[4], m_act[4];
    bit         m_ovf[4];

    always #4 clk = ~clk;

    comp_code_unit #(.GAIN_KEEP(GK)) dut (
        .clk(clk), .rst_n(rst_n), .raw_code_i(raw), .ready_i(rdy),
        .bus_valid_i(bv), .bus_op_i(bop), .bus_addr_i(badr), .bus_be_i(bbe),
        .bus_wdata_i(bwd), .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
        .gain_code_o(gain_o), .term_code_o(term_o), .tx_code_o(tx_o),
        .iref_code_o(iref_o));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] f_code(input logic [7:0] r, input logic [7:0] s, input logic [7:0] o);
        int p, v;
        p = (int'(r) * int'(s)) / 128;
        v = p + (o > 127 ? int'(o) - 256 : int'(o));
        if (v < 0) v = 0;
        if (v > 255) v = 255;
        return 8'(v);
    endfunction

    function automatic logic [7:0] f_final(input int l);
        return m_ovf[l] ? m_ovv[l] : f_code(raw[l*8 +: 8], m_scale[l], m_off[l]);
    endfunction

    function automatic logic [31:0] f_word(input int a);
        logic [31:0] w = '0;
        for (int l = 0; l < 4; l++)
            case (a)
                0: w[l*8 +: 8] = f_final(l);
                1: w[l*8 +: 8] = m_scale[l];
                2: w[l*8 +: 8] = m_off[l];
                default: w[l*8 +: 8] = 8'h00;
            endcase
        return w;
    endfunction

    task automatic model_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        for (int l = 0; l < 4; l++)
            if (be[l])
                case (a)
                    2'd0: begin m_ovv[l] = d[l*8 +: 8]; m_ovf[l] = 1; end
                    2'd1: begin m_scale[l] = d[l*8 +: 8]; m_ovf[l] = 0; end
                    2'd2: begin m_off[l] = d[l*8 +: 8]; m_ovf[l] = 0; end
                    default: ;
                endcase
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bv = 1; bop = 1; badr = a; bbe = be; bwd = d;
        @(negedge clk);
        bv = 0; bbe = 0;
        model_write(a, be, d);
    endtask

    task automatic bus_read(input string req, input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bv = 1; bop = 0; badr = a;
        @(negedge clk);
        bv = 0;
        chk({req, " rvalid"}, {31'd0, rvalid}, 32'd1);
        d = rdata;
    endtask

    task automatic read_chk(input string req, input logic [1:0] a);
        logic [31:0] d;
        bus_read(req, a, d);
        chk(req, d, f_word(a));
    endtask

    task automatic set_raw(input int l, input logic [7:0] v);
        @(negedge clk);
        raw[l*8 +: 8] = v;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        rdy = m;
        for (int l = 0; l < 4; l++) if (m[l]) m_act[l] = f_final(l);
        @(negedge clk);
        rdy = 0;
    endtask

    task automatic out_chk(input string req);
        chk({req, " gain"}, 32'(gain_o), 32'(m_act[3][7 -: GK]));
        chk({req, " term"}, 32'(term_o), 32'(m_act[2][7:1]));
        chk({req, " tx"},   32'(tx_o),   32'(m_act[1][7:1]));
        chk({req, " iref"}, 32'(iref_o), 32'(m_act[0][7:2]));
    endtask

    task automatic t_reset;  // R1
        read_chk("R1 final", 0);
        read_chk("R1 scale", 1);
        read_chk("R1 offset", 2);
        chk("R1 gain literal", 32'(gain_o), 32'h20);
        chk("R1 iref literal", 32'(iref_o), 32'h20);
        out_chk("R1");
    endtask

    task automatic t_compute;  // R2, R6
        set_raw(3, 8'h64); set_raw(2, 8'h64); set_raw(1, 8'hC8); set_raw(0, 8'h33);
        bus_write(1, 4'hF, 32'hC0_80_40_00);
        read_chk("R2 scaled", 0);
        bus_write(2, 4'hF, 32'h05_FE_00_07);
        read_chk("R2 offset", 0);
        chk("R2 literal", f_word(0), 32'h9B_62_64_07);
    endtask

    task automatic t_sat;  // R3, R4
        logic [31:0] d;
        set_raw(3, 8'hF0); set_raw(0, 8'h10);
        bus_write(1, 4'b1001, 32'hFF_00_00_40);
        bus_write(2, 4'b1001, 32'h05_00_00_EC);
        bus_read("R3 R4", 0, d);
        chk("R3 clamp high", 32'(d[31:24]), 32'hFF);
        chk("R4 clamp low", 32'(d[7:0]), 32'h00);
    endtask

    task automatic t_override;  // R5, R7
        logic [31:0] d;
        bus_write(0, 4'b0100, 32'h11_A5_22_33);
        bus_read("R5", 0, d);
        chk("R5 stored", 32'(d[23:16]), 32'hA5);
        chk("R7 other lanes", d, f_word(0));
        set_raw(2, 8'h11);
        read_chk("R5 raw ignored", 0);
        read_chk("R7 scale lanes", 1);
    endtask

    task automatic t_clear;  // R6
        logic [31:0] d;
        bus_write(2, 4'b0100, 32'hAA_01_BB_CC);
        bus_read("R6", 0, d);
        chk("R6 recomputed", 32'(d[23:16]), 32'h12);
        read_chk("R7 offset lanes", 2);
    endtask

    task automatic t_hold;  // R8, R9
        out_chk("R8 before strobe");
        set_raw(1, 8'h40);
        out_chk("R8 raw change");
        pulse(4'b1000);
        out_chk("R9 gain only");
        pulse(4'b0111);
        out_chk("R9 all lanes");
    endtask

    task automatic t_same;  // R10
        @(negedge clk);
        bv = 1; bop = 1; badr = 0; bbe = 4'b0001; bwd = 32'h0000_003C; rdy = 4'b0001;
        @(negedge clk);
        bv = 0; bbe = 0; rdy = 0;
        model_write(0, 4'b0001, 32'h0000_003C);
        m_act[0] = 8'h3C;
        chk("R10 iref", 32'(iref_o), 32'h0F);
        out_chk("R10");
    endtask

    task automatic t_spare;  // R11
        logic [31:0] d;
        bus_write(3, 4'hF, 32'hFFFF_FFFF);
        bus_read("R11 spare", 3, d);
        chk("R11 spare zero", d, 32'h0);
        read_chk("R11 final kept", 0);
        read_chk("R11 scale kept", 1);
        @(negedge clk);
        chk("R11 rvalid idle", {31'd0, rvalid}, 32'd0);
    endtask

    initial begin
        for (int l = 0; l < 4; l++) begin
            m_scale[l] = 8'h80; m_off[l] = 8'h00; m_ovv[l] = 8'h80;
            m_ovf[l] = 1; m_act[l] = 8'h80;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_compute();
        t_sat();
        t_override();
        t_clear();
        t_hold();
        t_same();
        t_spare();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule